// File: doc/BRIEF.md
# Cycle-Start Source Selector with SYNC Fallback

This block produces the cycle-start events for a switching controller. All of its logic runs on one fast system clock. It has two timing sources. The first is an internal tick divider that fires once every `INT_PERIOD` system-clock cycles. The second is an external SYNC pin. That pin is asynchronous, so it is first passed through a flop synchroniser and then edge-detected.

The first SYNC rising edge the block detects moves it to external timing at once, with no qualification window. After that, every SYNC rising edge gives one cycle-start pulse. If the pin goes silent for two internal periods, the block returns to the divider. The divider then restarts from zero, so no pulse is lost or doubled at the handover.

While the soft-start input is high, SYNC has no effect and the divider alone sets the timing. The intended external rate is roughly two-thirds to four-thirds of the internal rate. All outputs are plain registered control signals with no handshake.

Top module: `cyc_start_sel`

## Requirements
- R1: A synchronous active-low reset selects the internal source and clears all counters. During and right after reset, `cyc_start`, `ext_active` and `sync_lost` are 0. The first internal pulse comes `INT_PERIOD` cycles after the last clock edge that sampled reset low.
- R2: On the internal source, `cyc_start` is high for exactly one cycle every `INT_PERIOD` cycles.
- R3: A 0-to-1 change on `sync_async` that is first sampled at clock edge k drives `cyc_start` high in the cycle that follows edge k+2. While the block is on the external source, each such rising edge gives exactly one pulse.
- R4: The first accepted SYNC edge sets `ext_active` in the same cycle as its pulse. No internal pulses follow.
- R5: On the external source, suppose no pulse occurs for 2×`INT_PERIOD` cycles after pulse cycle E. Then in cycle E+2×`INT_PERIOD`, `ext_active` drops and `sync_lost` is high for that one cycle only.
- R6: After a fallback in cycle X, internal pulses fall in cycles X+`INT_PERIOD`, X+2×`INT_PERIOD`, and so on.
- R7: Suppose a SYNC edge's pulse lands in the cycle where the timeout would expire. Then the edge wins: `ext_active` stays 1 and `sync_lost` stays 0.
- R8: Suppose an accepted SYNC edge and an internal tick fall in the same cycle. Then exactly one pulse is produced, and the block moves to the external source.
- R9: While `ss_active` is high, SYNC edges give no pulse and `ext_active` is 0. If `ss_active` rises while the block is external, `ext_active` drops one cycle later without `sync_lost`. The internal pulses then begin `INT_PERIOD` cycles after that drop.
- R10: If SYNC is held high while `ss_active` falls, that counts as no edge. Only a later 0-to-1 change is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_async | input | 1 | External SYNC pin, asynchronous to clk |
| ss_active | input | 1 | High during soft start; SYNC is then ignored |
| cyc_start | output | 1 | One-cycle cycle-start pulse |
| ext_active | output | 1 | 1 while SYNC sets the timing |
| sync_lost | output | 1 | One-cycle pulse when the block falls back after SYNC goes silent |

## Verification
Two pairs of functions can collide in a single cycle.

The first pair is an internal tick and a newly accepted SYNC edge. The bench provokes this by raising SYNC three cycles before a predicted internal pulse. It then expects a single pulse, with `ext_active` set in that same cycle.

The second pair is the expiry of the silence timeout and an arriving edge. The bench places an edge's pulse exactly 2×`INT_PERIOD` cycles after the previous one and expects no fallback. It then repeats the test one cycle later and expects a fallback followed at once by a return to external timing, with no internal pulse in between.

// File: rtl/syncsw_pkg.sv
package syncsw_pkg;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } src_e;

  // Bits needed to hold the values 0 .. n-1.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/syncsw_edge.sv
module syncsw_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sr;
  logic              last;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last <= 1'b0;
    else        last <= sr[STAGES-1];
  end

  assign rise = sr[STAGES-1] & ~last;
endmodule

// File: rtl/syncsw_osc.sv
module syncsw_osc
  import syncsw_pkg::*;
#(
  parameter int unsigned PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned W = cnt_bits(PERIOD);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/syncsw_watch.sv
module syncsw_watch
  import syncsw_pkg::*;
#(
  parameter int unsigned LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic kick,
  output logic expire
);
  localparam int unsigned W = cnt_bits(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm || kick) cnt <= '0;
    else if (cnt != LAST)       cnt <= cnt + 1'b1;
  end

  assign expire = arm && !kick && (cnt == LAST);
endmodule

// File: rtl/cyc_start_sel.sv
module cyc_start_sel
  import syncsw_pkg::*;
#(
  parameter int unsigned INT_PERIOD  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_async,
  input  logic ss_active,
  output logic cyc_start,
  output logic ext_active,
  output logic sync_lost
);
  localparam int unsigned TIMEOUT = 2 * INT_PERIOD;

  src_e src_q, src_d;
  logic rise, edge_ok, tick, expire;

  syncsw_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (sync_async),
    .rise (rise)
  );

  assign edge_ok = rise & ~ss_active;

  // The divider is held at zero while external timing is in use.
  syncsw_osc #(.PERIOD(INT_PERIOD)) u_osc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (src_q == SRC_INT),
    .tick (tick)
  );

  syncsw_watch #(.LIMIT(TIMEOUT)) u_watch (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   ((src_q == SRC_EXT) && !ss_active),
    .kick  (edge_ok),
    .expire(expire)
  );

  always_comb begin
    src_d = src_q;
    if (ss_active)    src_d = SRC_INT;
    else if (edge_ok) src_d = SRC_EXT;
    else if (expire)  src_d = SRC_INT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q     <= SRC_INT;
      cyc_start <= 1'b0;
      sync_lost <= 1'b0;
    end else begin
      src_q     <= src_d;
      cyc_start <= edge_ok | ((src_q == SRC_INT) & tick);
      sync_lost <= expire;
    end
  end

  assign ext_active = (src_q == SRC_EXT);
endmodule

// File: rtl/syncsw_chk.sv
module syncsw_chk #(
  parameter int unsigned INT_PERIOD = 16
) (
  input logic clk,
  input logic rst_n,
  input logic ss_active,
  input logic cyc_start,
  input logic ext_active,
  input logic sync_lost
);
  localparam int unsigned T  = 2 * INT_PERIOD;
  localparam int unsigned GW = $clog2(T + 2) + 1;

  logic [GW-1:0] gap_q, gap_now;
  assign gap_now = cyc_start ? '0 : gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gap_q <= '0;
    else if (gap_now < GW'(T + 1)) gap_q <= gap_now + 1'b1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!ext_active && !cyc_start && !sync_lost));

  a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start);

  a_r4_ext_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_active) |-> cyc_start);

  a_r5_lost_drops_ext: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> (!ext_active && $past(ext_active)));

  a_r5_lost_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |=> !sync_lost);

  a_r5_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ext_active |-> (gap_now < GW'(T)));

  a_r9_ss_forces_int: assert property (@(posedge clk) disable iff (!rst_n)
    ss_active |=> !ext_active);
endmodule

bind cyc_start_sel syncsw_chk #(.INT_PERIOD(INT_PERIOD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ss_active (ss_active),
  .cyc_start (cyc_start),
  .ext_active(ext_active),
  .sync_lost (sync_lost)
);

// File: tb/tb_cyc_start_sel.sv
module tb_cyc_start_sel;
  localparam int CLK_PERIOD = 10;
  localparam int P = 16;
  localparam int T = 2 * P;

  logic clk = 1'b0, rst_n = 1'b0, sync_async = 1'b0, ss_active = 1'b0;
  logic cyc_start, ext_active, sync_lost;

  cyc_start_sel #(.INT_PERIOD(P)) dut (
    .clk(clk), .rst_n(rst_n), .sync_async(sync_async), .ss_active(ss_active),
    .cyc_start(cyc_start), .ext_active(ext_active), .sync_lost(sync_lost)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0, n_fail = 0;
  int exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  task automatic expect_pulse(input int c, input string tag);
    exp_q.push_back(c);
    tag_q.push_back(tag);
  endtask

  task automatic to_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      while (exp_q.size() > 0 && exp_q[0] < cyc) begin
        chk(1'b0, tag_q[0], "missed pulse, now at cycle", cyc, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (cyc_start) begin
        if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected pulse at cycle", cyc, -1);
        else begin
          chk(exp_q[0] == cyc, tag_q[0], "pulse cycle", cyc, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int r, n0, l, f0, fi, e, e2, e3, c;
    repeat (4) @(negedge clk);
    chk(cyc_start == 1'b0, "R1", "cyc_start in reset", cyc_start, 0);
    chk(ext_active == 1'b0, "R1", "ext_active in reset", ext_active, 0);
    chk(sync_lost == 1'b0, "R1", "sync_lost in reset", sync_lost, 0);
    rst_n = 1'b1;
    r = cyc;
    expect_pulse(r + P, "R1");
    expect_pulse(r + 2*P, "R2");
    expect_pulse(r + 3*P, "R2");

    // First external edge
    n0 = r + 3*P + 2;
    expect_pulse(n0 + 3, "R4");
    to_cyc(n0); sync_async = 1'b1;
    to_cyc(n0 + 2); chk(ext_active == 1'b0, "R3", "ext_active before sync latency", ext_active, 0);
    to_cyc(n0 + 3); chk(ext_active == 1'b1, "R4", "ext_active on first edge", ext_active, 1);
    to_cyc(n0 + 10); sync_async = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      expect_pulse(n0 + 20*k + 3, "R3");
      to_cyc(n0 + 20*k); sync_async = 1'b1;
      to_cyc(n0 + 20*k + 10); sync_async = 1'b0;
    end

    // Silence -> fallback
    l  = n0 + 63;
    f0 = l + T;
    fi = f0 + P;
    expect_pulse(fi, "R6");
    expect_pulse(fi + P, "R6");
    expect_pulse(fi + 2*P, "R6");
    to_cyc(f0 - 1);
    chk(ext_active == 1'b1, "R5", "ext_active before timeout", ext_active, 1);
    chk(sync_lost == 1'b0, "R5", "sync_lost before timeout", sync_lost, 0);
    to_cyc(f0);
    chk(ext_active == 1'b0, "R5", "ext_active at timeout", ext_active, 0);
    chk(sync_lost == 1'b1, "R5", "sync_lost at timeout", sync_lost, 1);
    to_cyc(f0 + 1);
    chk(sync_lost == 1'b0, "R5", "sync_lost one cycle only", sync_lost, 0);

    // Edge coinciding with internal tick
    e = fi + 3*P;
    expect_pulse(e, "R8");
    to_cyc(e - 3); sync_async = 1'b1;
    to_cyc(e); chk(ext_active == 1'b1, "R8", "ext_active after coincident edge", ext_active, 1);
    to_cyc(e + 2); sync_async = 1'b0;

    // Edge on the expiry cycle
    e2 = e + T;
    expect_pulse(e2, "R7");
    to_cyc(e2 - 3); sync_async = 1'b1;
    to_cyc(e2);
    chk(ext_active == 1'b1, "R7", "ext_active with edge at expiry", ext_active, 1);
    chk(sync_lost == 1'b0, "R7", "sync_lost with edge at expiry", sync_lost, 0);
    to_cyc(e2 + 2); sync_async = 1'b0;

    // Edge one cycle late: fallback then immediate return
    e3 = e2 + T + 1;
    expect_pulse(e3, "R5");
    to_cyc(e3 - 3); sync_async = 1'b1;
    to_cyc(e2 + T);
    chk(ext_active == 1'b0, "R5", "ext_active late edge fallback", ext_active, 0);
    chk(sync_lost == 1'b1, "R5", "sync_lost late edge fallback", sync_lost, 1);
    to_cyc(e3); chk(ext_active == 1'b1, "R4", "ext_active re-acquire", ext_active, 1);
    to_cyc(e3 + 2); sync_async = 1'b0;

    // Soft start while external
    c = e3 + 5;
    for (int k = 1; k <= 5; k++) expect_pulse(c + 1 + k*P, "R9");
    to_cyc(c); ss_active = 1'b1;
    to_cyc(c + 1);
    chk(ext_active == 1'b0, "R9", "ext_active after soft start", ext_active, 0);
    chk(sync_lost == 1'b0, "R9", "no sync_lost on soft start", sync_lost, 0);
    to_cyc(c + 10); sync_async = 1'b1;
    to_cyc(c + 15); sync_async = 1'b0;
    to_cyc(c + 30); sync_async = 1'b1;
    to_cyc(c + 35); sync_async = 1'b0;
    to_cyc(c + 36); chk(ext_active == 1'b0, "R9", "ext_active under soft start", ext_active, 0);
    to_cyc(c + 40); sync_async = 1'b1;
    to_cyc(c + 60); ss_active = 1'b0;
    to_cyc(c + 66); chk(ext_active == 1'b0, "R10", "held-high SYNC after release", ext_active, 0);
    to_cyc(c + 70); sync_async = 1'b0;
    expect_pulse(c + 93, "R10");
    expect_pulse(c + 93 + T + P, "R6");
    expect_pulse(c + 93 + T + 2*P, "R6");
    to_cyc(c + 90); sync_async = 1'b1;
    to_cyc(c + 93); chk(ext_active == 1'b1, "R10", "fresh edge after release", ext_active, 1);
    to_cyc(c + 95); sync_async = 1'b0;
    to_cyc(c + 93 + T + 2*P + 3);
    chk(exp_q.size() == 0, "R2", "pending expected pulses", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule